// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block steps a small processor system between full operation and three power-saving depths. In the lightest depth only the processor clock stops. In the middle depth every core clock and every oscillator stops, but state is kept. In the deepest depth the core supply is switched off. The processor asks for a depth with a request code. The controller then drives the clock gates, the oscillator and PLL enables, and the regulator mode for that depth. It watches only the wakeup sources that are valid for the depth it is in.

Leaving the middle depth resumes execution. The internal RC oscillator is brought back first. The core clocks are ungated next, and a one-cycle clock-ready handshake comes before the processor clock. Leaving the deepest depth never resumes. It always runs a reset pulse of fixed length, raises a flag that records where the reset came from, and keeps a retention-lost indication. A wake-cause register and a line index record the first event that ended each power-saving period.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After `rst_n` is released, the block is in Run (`mode_status`=0) with `cpu_clk_en`, `core_clk_en` and `hsi_en` high, `reg_mode`=0 (main), and `standby_flag`, `retention_lost`, `sys_reset` and `wake_src` all 0.
- R2: `req_mode` is sampled only when `req_valid` is high in Run. Code 1 selects Sleep, 2 selects Stop and 3 selects Standby, and the state changes at that same edge. Code 0, and any request made outside Run, has no effect. `mode_status` encodes Run=0, Sleep=1, Stop=2, oscillator-restart=3, clock-ready=4, Standby=5 and reset=6.
- R3: In Sleep, `cpu_clk_en` is low while `core_clk_en` and `hsi_en` stay high. A high `irq_evt` returns the block to Run at the next edge and sets `wake_src`=1.
- R4: In Stop, all clock gates and oscillator enables are low. `reg_mode` is 1 (low-power) if `stop_lp_sel` was high on the accepted request, and 0 otherwise. Later changes to `stop_lp_sel` have no effect.
- R5: In Stop, any bit of `exti_in` ends the stop. `wake_src` becomes 2 and `wake_line` becomes the lowest set bit. `hsi_en` then rises with core clocks still gated until `hsi_ready` is seen high. After that comes one cycle with `core_clk_en` and `clk_ready` high and `cpu_clk_en` low, and then Run.
- R6: In Standby, `reg_mode`=2 (off), all clocks and oscillators are off, and `retention_lost` is high.
- R7: Standby ends only on one of four events: a rising edge of `wkup_pin`, seen after a 2-stage synchroniser, `rtc_alarm`, `nrst_req`, or `iwdg_req`. `irq_evt`, `exti_in`, and a `wkup_pin` already high at entry are ignored. The wake codes are pin=3, RTC=4, reset pin=5 and watchdog=6, in the priority reset pin > watchdog > pin > RTC.
- R8: `nrst_req` or `iwdg_req`, in any state other than reset, starts a reset sequence. During it `sys_reset` is high for exactly `RST_CYCLES` cycles (8), with `hsi_en` high, `reg_mode`=0 and both clock gates low. Then the block enters Run. Reset requests made during the sequence are ignored.
- R9: `standby_flag` is set when a reset sequence starts from Standby. It is cleared when a sequence starts from any other state. Otherwise it holds.
- R10: `retention_lost` stays high after a Standby exit until the next accepted low-power request, or until a reset sequence that starts outside Standby.
- R11: `wake_src` and `wake_line` are cleared on every accepted low-power request. They hold their value through Run, and through reset sequences that start outside Standby.
- R12: `hse_en` follows `hse_want` and `pll_en` follows `pll_want`, but only in Run and Sleep. In every other state both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested depth: 1 Sleep, 2 Stop, 3 Standby |
| stop_lp_sel | input | 1 | Regulator low-power select for Stop |
| hse_want | input | 1 | Software enable for the crystal oscillator |
| pll_want | input | 1 | Software enable for the PLL |
| irq_evt | input | 1 | Any interrupt or event (Sleep wakeup) |
| exti_in | input | NUM_EXTI | External-interrupt wakeup lines for Stop |
| wkup_pin | input | 1 | Asynchronous dedicated wakeup pin |
| rtc_alarm | input | 1 | Real-time-clock alarm |
| nrst_req | input | 1 | External reset pin request |
| iwdg_req | input | 1 | Independent watchdog reset request |
| hsi_ready | input | 1 | Internal RC oscillator stable |
| cpu_clk_en | output | 1 | Processor clock gate |
| core_clk_en | output | 1 | Core-domain clock gate |
| hsi_en | output | 1 | Internal RC oscillator enable |
| hse_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| reg_mode | output | 2 | Regulator: 0 main, 1 low-power, 2 off |
| retention_lost | output | 1 | Core state was lost in Standby |
| sys_reset | output | 1 | System reset pulse |
| clk_ready | output | 1 | Clock-ready handshake after Stop |
| standby_flag | output | 1 | Last reset came from Standby exit |
| wake_src | output | 3 | Cause of the last wakeup |
| wake_line | output | EXTI_IW | Index of the wakeup line for Stop wakes |
| mode_status | output | 3 | Current sequencer state |

## Verification
Clock gates, enables and the regulator mode change at the same edge that samples a request or a wake event. The bench therefore compares them 1 ns after each rising edge against a behavioural model that is advanced at that edge. The wake cause, the standby flag and the retention indication are registered at the same edge as the state change, so they are compared in the same slot. A rise on the wakeup pin takes effect at the third edge after it. The reset pulse runs for `RST_CYCLES` sample slots, and the bench counts those slots directly. A step of the oscillator-restart handshake is due only after `hsi_ready` is sampled high, so directed checks wait for the state rather than a fixed count.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_SLEEP    = 3'd1,
      ST_STOP     = 3'd2,
      ST_WAKE_OSC = 3'd3,
      ST_WAKE_CLK = 3'd4,
      ST_STBY     = 3'd5,
      ST_RST      = 3'd6
   } lpm_state_e;

   typedef enum logic [1:0] {
      REG_MAIN   = 2'd0,
      REG_LOWPWR = 2'd1,
      REG_OFF    = 2'd2
   } reg_mode_e;

   typedef enum logic [2:0] {
      WK_NONE = 3'd0,
      WK_IRQ  = 3'd1,
      WK_EXTI = 3'd2,
      WK_PIN  = 3'd3,
      WK_RTC  = 3'd4,
      WK_NRST = 3'd5,
      WK_WDG  = 3'd6
   } wake_src_e;

   localparam logic [1:0] REQ_NONE  = 2'd0;
   localparam logic [1:0] REQ_SLEEP = 2'd1;
   localparam logic [1:0] REQ_STOP  = 2'd2;
   localparam logic [1:0] REQ_STBY  = 2'd3;

   typedef struct packed {
      logic      cpu;
      logic      core;
      logic      hsi;
      logic      ext_osc;
      logic      pll;
      logic      rdy;
      logic      rst;
      reg_mode_e regm;
   } lpm_ctl_s;
endpackage

// File: rtl/lpm_edge_sync.sv
module lpm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lpm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/lpm_line_pick.sv
module lpm_line_pick #(
   parameter int N  = 19,
   parameter int IW = 5
) (
   input  logic [N-1:0]  lines,
   output logic          any,
   output logic [IW-1:0] idx
);
   logic [N:0]   seen;
   logic [N-1:0] first;

   assign seen[0] = 1'b0;
   generate
      for (genvar i = 0; i < N; i++) begin : g_line
         assign first[i]  = lines[i] & ~seen[i];
         assign seen[i+1] = seen[i] | lines[i];
      end
   endgenerate

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (first[i]) idx = idx | IW'(i);
      end
   end
endmodule

// File: rtl/lpm_rst_timer.sv
module lpm_rst_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("lpm_rst_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= CW'(CYCLES - 1);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl #(
   parameter int NUM_EXTI    = 19,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYCLES  = 8,
   localparam int EXTI_IW    = (NUM_EXTI > 1) ? $clog2(NUM_EXTI) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_mode,
   input  logic                stop_lp_sel,
   input  logic                hse_want,
   input  logic                pll_want,
   input  logic                irq_evt,
   input  logic [NUM_EXTI-1:0] exti_in,
   input  logic                wkup_pin,
   input  logic                rtc_alarm,
   input  logic                nrst_req,
   input  logic                iwdg_req,
   input  logic                hsi_ready,
   output logic                cpu_clk_en,
   output logic                core_clk_en,
   output logic                hsi_en,
   output logic                hse_en,
   output logic                pll_en,
   output logic [1:0]          reg_mode,
   output logic                retention_lost,
   output logic                sys_reset,
   output logic                clk_ready,
   output logic                standby_flag,
   output logic [2:0]          wake_src,
   output logic [EXTI_IW-1:0]  wake_line,
   output logic [2:0]          mode_status
);
   import lpm_pkg::*;

   generate
      if (NUM_EXTI < 1 || NUM_EXTI > 64) begin : g_bad_exti
         $error("lpm_seq_ctrl: NUM_EXTI out of range");
      end
   endgenerate

   lpm_state_e         state_q, state_d;
   logic               lp_q, lp_d;
   logic               flag_q, flag_d;
   logic               ret_q, ret_d;
   wake_src_e          src_q, src_d;
   logic [EXTI_IW-1:0] line_q, line_d;
   logic               pin_rise, exti_any, rst_load, rst_done;
   logic [EXTI_IW-1:0] exti_idx;
   lpm_ctl_s           ctl;

   lpm_edge_sync #(.STAGES(SYNC_STAGES)) u_wk_sync (
      .clk(clk), .rst_n(rst_n), .din(wkup_pin), .rise(pin_rise)
   );

   lpm_line_pick #(.N(NUM_EXTI), .IW(EXTI_IW)) u_pick (
      .lines(exti_in), .any(exti_any), .idx(exti_idx)
   );

   lpm_rst_timer #(.CYCLES(RST_CYCLES)) u_rst_tmr (
      .clk(clk), .rst_n(rst_n), .load(rst_load), .done(rst_done)
   );

   always_comb begin
      state_d  = state_q;
      lp_d     = lp_q;
      flag_d   = flag_q;
      ret_d    = ret_q;
      src_d    = src_q;
      line_d   = line_q;
      rst_load = 1'b0;
      if ((nrst_req || iwdg_req) && state_q != ST_RST) begin
         state_d  = ST_RST;
         rst_load = 1'b1;
         flag_d   = (state_q == ST_STBY);
         if (state_q == ST_STBY) src_d = nrst_req ? WK_NRST : WK_WDG;
         else                    ret_d = 1'b0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (req_valid && req_mode != REQ_NONE) begin
                  src_d  = WK_NONE;
                  line_d = '0;
                  ret_d  = 1'b0;
                  if (req_mode == REQ_SLEEP) begin
                     state_d = ST_SLEEP;
                  end else if (req_mode == REQ_STOP) begin
                     state_d = ST_STOP;
                     lp_d    = stop_lp_sel;
                  end else begin
                     state_d = ST_STBY;
                     ret_d   = 1'b1;
                  end
               end
            end
            ST_SLEEP: begin
               if (irq_evt) begin
                  state_d = ST_RUN;
                  src_d   = WK_IRQ;
               end
            end
            ST_STOP: begin
               if (exti_any) begin
                  state_d = ST_WAKE_OSC;
                  src_d   = WK_EXTI;
                  line_d  = exti_idx;
               end
            end
            ST_WAKE_OSC: if (hsi_ready) state_d = ST_WAKE_CLK;
            ST_WAKE_CLK: state_d = ST_RUN;
            ST_STBY: begin
               if (pin_rise || rtc_alarm) begin
                  state_d  = ST_RST;
                  rst_load = 1'b1;
                  flag_d   = 1'b1;
                  src_d    = pin_rise ? WK_PIN : WK_RTC;
               end
            end
            ST_RST: if (rst_done) state_d = ST_RUN;
            default: state_d = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         lp_q    <= 1'b0;
         flag_q  <= 1'b0;
         ret_q   <= 1'b0;
         src_q   <= WK_NONE;
         line_q  <= '0;
      end else begin
         state_q <= state_d;
         lp_q    <= lp_d;
         flag_q  <= flag_d;
         ret_q   <= ret_d;
         src_q   <= src_d;
         line_q  <= line_d;
      end
   end

   always_comb begin
      ctl = '{cpu: 1'b0, core: 1'b0, hsi: 1'b0, ext_osc: 1'b0, pll: 1'b0,
              rdy: 1'b0, rst: 1'b0, regm: REG_MAIN};
      unique case (state_q)
         ST_RUN: begin
            ctl.cpu = 1'b1; ctl.core = 1'b1; ctl.hsi = 1'b1;
            ctl.ext_osc = hse_want; ctl.pll = pll_want;
         end
         ST_SLEEP: begin
            ctl.core = 1'b1; ctl.hsi = 1'b1;
            ctl.ext_osc = hse_want; ctl.pll = pll_want;
         end
         ST_STOP:     ctl.regm = lp_q ? REG_LOWPWR : REG_MAIN;
         ST_WAKE_OSC: ctl.hsi = 1'b1;
         ST_WAKE_CLK: begin
            ctl.core = 1'b1; ctl.hsi = 1'b1; ctl.rdy = 1'b1;
         end
         ST_STBY:     ctl.regm = REG_OFF;
         ST_RST: begin
            ctl.hsi = 1'b1; ctl.rst = 1'b1;
         end
         default: ctl.regm = REG_MAIN;
      endcase
   end

   assign cpu_clk_en     = ctl.cpu;
   assign core_clk_en    = ctl.core;
   assign hsi_en         = ctl.hsi;
   assign hse_en         = ctl.ext_osc;
   assign pll_en         = ctl.pll;
   assign clk_ready      = ctl.rdy;
   assign sys_reset      = ctl.rst;
   assign reg_mode       = ctl.regm;
   assign retention_lost = ret_q;
   assign standby_flag   = flag_q;
   assign wake_src       = src_q;
   assign wake_line      = line_q;
   assign mode_status    = state_q;
endmodule

// File: rtl/lpm_seq_ctrl_chk.sv
module lpm_seq_ctrl_chk #(
   parameter int RST_CYCLES = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_mode,
   input logic       stop_lp_sel,
   input logic       nrst_req,
   input logic       iwdg_req,
   input logic       rtc_alarm,
   input logic       hsi_ready,
   input logic       pin_rise,
   input logic       cpu_clk_en,
   input logic       core_clk_en,
   input logic       hsi_en,
   input logic       hse_en,
   input logic       pll_en,
   input logic [1:0] reg_mode,
   input logic       retention_lost,
   input logic       sys_reset,
   input logic       clk_ready,
   input logic       standby_flag,
   input logic [2:0] wake_src,
   input logic [2:0] mode_status
);
   logic [31:0] rst_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rst_len <= '0;
      else if (sys_reset) rst_len <= rst_len + 1;
      else                rst_len <= '0;
   end

   // R3
   p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 3'd0 && req_valid && req_mode == 2'd1 && !nrst_req && !iwdg_req)
      |=> (!cpu_clk_en && core_clk_en));

   // R4
   p_stop_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 3'd0 && req_valid && req_mode == 2'd2 && !nrst_req && !iwdg_req)
      |=> (!core_clk_en && !hsi_en && !hse_en && !pll_en &&
           reg_mode == ($past(stop_lp_sel) ? 2'd1 : 2'd0)));

   // R6
   p_stby_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 3'd0 && req_valid && req_mode == 2'd3 && !nrst_req && !iwdg_req)
      |=> (reg_mode == 2'd2 && retention_lost && !hsi_en));

   // R5
   p_cpu_after_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_clk_en) && !$past(sys_reset)) |-> $past(core_clk_en));

   p_ready_after_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clk_ready |-> $past(hsi_ready));

   p_ready_then_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_ready && !nrst_req && !iwdg_req) |=> cpu_clk_en);

   // R7
   p_stby_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_mode == 2'd2 && !nrst_req && !iwdg_req && !rtc_alarm && !pin_rise)
      |=> reg_mode == 2'd2);

   // R8
   p_rst_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset |-> (rst_len < RST_CYCLES));

   p_rst_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_reset) |-> (rst_len == RST_CYCLES && cpu_clk_en));

   // R9
   p_flag_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_reset) |-> (standby_flag == ($past(reg_mode) == 2'd2)));

   // R11
   p_src_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 3'd0 && $past(mode_status) == 3'd0) |-> $stable(wake_src));
endmodule

bind lpm_seq_ctrl lpm_seq_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
   .stop_lp_sel(stop_lp_sel), .nrst_req(nrst_req), .iwdg_req(iwdg_req),
   .rtc_alarm(rtc_alarm), .hsi_ready(hsi_ready), .pin_rise(pin_rise),
   .cpu_clk_en(cpu_clk_en), .core_clk_en(core_clk_en), .hsi_en(hsi_en),
   .hse_en(hse_en), .pll_en(pll_en), .reg_mode(reg_mode),
   .retention_lost(retention_lost), .sys_reset(sys_reset),
   .clk_ready(clk_ready), .standby_flag(standby_flag),
   .wake_src(wake_src), .mode_status(mode_status)
);

// File: tb/tb_lpm_seq_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_seq_ctrl;
   localparam int NE  = 19;
   localparam int IW  = 5;
   localparam int RSTC = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, stop_lp_sel = 0, hse_want = 0, pll_want = 0, irq_evt = 0;
   logic [1:0] req_mode = 0;
   logic [NE-1:0] exti_in = '0;
   logic wkup_pin = 0, rtc_alarm = 0, nrst_req = 0, iwdg_req = 0, hsi_ready = 0;
   logic cpu_clk_en, core_clk_en, hsi_en, hse_en, pll_en, retention_lost;
   logic sys_reset, clk_ready, standby_flag;
   logic [1:0] reg_mode;
   logic [2:0] wake_src, mode_status;
   logic [IW-1:0] wake_line;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   lpm_seq_ctrl #(.NUM_EXTI(NE), .SYNC_STAGES(2), .RST_CYCLES(RSTC)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .stop_lp_sel(stop_lp_sel), .hse_want(hse_want), .pll_want(pll_want),
      .irq_evt(irq_evt), .exti_in(exti_in), .wkup_pin(wkup_pin),
      .rtc_alarm(rtc_alarm), .nrst_req(nrst_req), .iwdg_req(iwdg_req),
      .hsi_ready(hsi_ready), .cpu_clk_en(cpu_clk_en), .core_clk_en(core_clk_en),
      .hsi_en(hsi_en), .hse_en(hse_en), .pll_en(pll_en), .reg_mode(reg_mode),
      .retention_lost(retention_lost), .sys_reset(sys_reset),
      .clk_ready(clk_ready), .standby_flag(standby_flag), .wake_src(wake_src),
      .wake_line(wake_line), .mode_status(mode_status)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_st, m_lp, m_cnt, m_flag, m_ret, m_src, m_line;
   int w1, w2, w3;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_lp = 0; m_cnt = 0; m_flag = 0; m_ret = 0; m_src = 0; m_line = 0;
         w1 = 0; w2 = 0; w3 = 0;
      end else begin
         int edge_seen;
         int low;
         edge_seen = (w2 == 1 && w3 == 0);
         w3 = w2; w2 = w1; w1 = int'(wkup_pin);
         low = -1;
         for (int i = NE - 1; i >= 0; i--) if (exti_in[i]) low = i;
         if ((nrst_req || iwdg_req) && m_st != 6) begin
            if (m_st == 5) begin
               m_flag = 1;
               m_src = nrst_req ? 5 : 6;
            end else begin
               m_flag = 0;
               m_ret = 0;
            end
            m_st = 6; m_cnt = RSTC;
         end else begin
            case (m_st)
               0: if (req_valid && req_mode != 0) begin
                     m_src = 0; m_line = 0; m_ret = 0;
                     if (req_mode == 1) m_st = 1;
                     else if (req_mode == 2) begin m_st = 2; m_lp = stop_lp_sel; end
                     else begin m_st = 5; m_ret = 1; end
                  end
               1: if (irq_evt) begin m_st = 0; m_src = 1; end
               2: if (low >= 0) begin m_st = 3; m_src = 2; m_line = low; end
               3: if (hsi_ready) m_st = 4;
               4: m_st = 0;
               5: if (edge_seen || rtc_alarm) begin
                     m_st = 6; m_cnt = RSTC; m_flag = 1;
                     m_src = edge_seen ? 3 : 4;
                  end
               6: begin
                     m_cnt--;
                     if (m_cnt == 0) m_st = 0;
                  end
               default: m_st = 0;
            endcase
         end
      end
   end

   always @(posedge clk) begin
      int e_cpu, e_core, e_hsi, e_hse, e_pll, e_rdy, e_rst, e_reg;
      #1;
      if (!done) begin
         e_cpu = 0; e_core = 0; e_hsi = 0; e_hse = 0; e_pll = 0; e_rdy = 0; e_rst = 0; e_reg = 0;
         case (m_st)
            0: begin e_cpu = 1; e_core = 1; e_hsi = 1; e_hse = hse_want; e_pll = pll_want; end
            1: begin e_core = 1; e_hsi = 1; e_hse = hse_want; e_pll = pll_want; end
            2: e_reg = m_lp;
            3: e_hsi = 1;
            4: begin e_core = 1; e_hsi = 1; e_rdy = 1; end
            5: e_reg = 2;
            6: begin e_hsi = 1; e_rst = 1; end
            default: ;
         endcase
         chk("R2 mode_status", mode_status, m_st);
         chk("R3 cpu_clk_en", cpu_clk_en, e_cpu);
         chk("R4 core_clk_en", core_clk_en, e_core);
         chk("R5 hsi_en", hsi_en, e_hsi);
         chk("R12 hse_en", hse_en, e_hse);
         chk("R12 pll_en", pll_en, e_pll);
         chk("R5 clk_ready", clk_ready, e_rdy);
         chk("R8 sys_reset", sys_reset, e_rst);
         chk("R4 reg_mode", reg_mode, e_reg);
         chk("R10 retention_lost", retention_lost, m_ret);
         chk("R9 standby_flag", standby_flag, m_flag);
         chk("R11 wake_src", wake_src, m_src);
         chk("R5 wake_line", wake_line, m_line);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic request(input logic [1:0] code);
      req_valid = 1; req_mode = code;
      cyc(1);
      req_valid = 0; req_mode = 0;
   endtask

   task automatic wait_state(input int s, input string tag);
      int n = 0;
      while (mode_status != 3'(s) && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk(tag, mode_status, s);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk("R1 mode", mode_status, 0);
      chk("R1 cpu", cpu_clk_en, 1);
      chk("R1 core", core_clk_en, 1);
      chk("R1 hsi", hsi_en, 1);
      chk("R1 reg", reg_mode, 0);
      chk("R1 flags", {standby_flag, retention_lost, sys_reset}, 0);
      chk("R1 src", wake_src, 0);

      // R2 code 0 ignored
      request(2'd0);
      cyc(1);
      chk("R2 code0 ignored", mode_status, 0);

      // R3 Sleep, R12 oscillator follow
      hse_want = 1; pll_want = 1;
      request(2'd1);
      chk("R3 sleep state", mode_status, 1);
      chk("R3 sleep cpu gated", cpu_clk_en, 0);
      chk("R12 hse kept in sleep", hse_en, 1);
      request(2'd2);
      chk("R2 request in sleep ignored", mode_status, 1);
      irq_evt = 1; cyc(1); irq_evt = 0;
      chk("R3 irq wake", mode_status, 0);
      chk("R3 irq code", wake_src, 1);

      // R4 Stop with low-power regulator, R5 wake
      stop_lp_sel = 1;
      request(2'd2);
      stop_lp_sel = 0;
      chk("R4 stop state", mode_status, 2);
      chk("R12 hse off in stop", hse_en, 0);
      cyc(2);
      chk("R4 regulator latched", reg_mode, 1);
      irq_evt = 1; cyc(1); irq_evt = 0;
      chk("R4 irq ignored in stop", mode_status, 2);
      exti_in[9] = 1; exti_in[5] = 1; cyc(1); exti_in = '0;
      chk("R5 osc restart", mode_status, 3);
      chk("R5 core gated during restart", core_clk_en, 0);
      chk("R5 lowest line", wake_line, 5);
      cyc(3);
      chk("R5 waits for oscillator", mode_status, 3);
      hsi_ready = 1; cyc(1); hsi_ready = 0;
      chk("R5 clock ready", clk_ready, 1);
      chk("R5 cpu still gated", cpu_clk_en, 0);
      cyc(1);
      chk("R5 back to run", cpu_clk_en, 1);

      // R4 Stop with main regulator
      request(2'd2);
      chk("R4 main regulator", reg_mode, 0);
      hsi_ready = 1;
      exti_in[18] = 1; cyc(1); exti_in = '0;
      chk("R5 line 18", wake_line, 18);
      cyc(2);
      hsi_ready = 0;
      chk("R5 run after stop", mode_status, 0);

      // R6/R7 Standby, pin already high
      wkup_pin = 1; cyc(4);
      request(2'd3);
      chk("R6 standby", mode_status, 5);
      chk("R6 regulator off", reg_mode, 2);
      chk("R6 retention lost", retention_lost, 1);
      irq_evt = 1; exti_in = '1; cyc(1); irq_evt = 0; exti_in = '0;
      cyc(6);
      chk("R7 held-high pin and irq ignored", mode_status, 5);
      wkup_pin = 0; cyc(4);
      wkup_pin = 1;
      wait_state(6, "R7 pin edge exit");
      chk("R7 pin code", wake_src, 3);
      chk("R9 flag set", standby_flag, 1);
      begin
         int n = 0;
         while (sys_reset && n < 100) begin n++; cyc(1); end
         chk("R8 reset length", n, RSTC);
      end
      chk("R8 run after reset", mode_status, 0);
      chk("R10 retention kept", retention_lost, 1);
      nrst_req = 0;

      // R10 cleared by next request
      request(2'd2);
      chk("R10 cleared on request", retention_lost, 0);
      chk("R11 src cleared", wake_src, 0);
      hsi_ready = 1; exti_in[0] = 1; cyc(1); exti_in = '0;
      cyc(2); hsi_ready = 0;

      // R7 RTC exit
      request(2'd3);
      cyc(2);
      rtc_alarm = 1; cyc(1); rtc_alarm = 0;
      chk("R7 rtc code", wake_src, 4);
      wait_state(0, "R8 run after rtc exit");

      // R7 priority: reset pin over watchdog
      request(2'd3);
      cyc(2);
      nrst_req = 1; iwdg_req = 1; cyc(1); nrst_req = 0; iwdg_req = 0;
      chk("R7 reset pin priority", wake_src, 5);
      chk("R9 flag from standby", standby_flag, 1);
      wait_state(0, "R8 run after pin reset");

      // R9/R11 reset from Run
      nrst_req = 1; cyc(1); nrst_req = 0;
      chk("R9 flag cleared", standby_flag, 0);
      chk("R11 src held", wake_src, 5);
      chk("R10 retention cleared", retention_lost, 0);
      iwdg_req = 1; cyc(1); iwdg_req = 0;
      chk("R8 request in reset ignored", mode_status, 6);
      wait_state(0, "R8 run after run reset");

      // watchdog reset from Stop, and from Standby
      request(2'd2);
      iwdg_req = 1; cyc(1); iwdg_req = 0;
      chk("R8 stop reset", mode_status, 6);
      wait_state(0, "R8 run again");
      wkup_pin = 0;
      request(2'd3);
      cyc(3);
      iwdg_req = 1; cyc(1); iwdg_req = 0;
      chk("R7 watchdog code", wake_src, 6);
      wait_state(0, "R8 final run");
      cyc(4);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule